// File: doc/BRIEF.md
# Lane-Splittable Unsigned Comparator

This block compares two 24-bit unsigned operands that are viewed as three 8-bit lanes. Two split controls decide, at run time, where the lane boundaries are. A set split bit keeps the lanes on either side of that boundary apart. A clear bit joins them into one wider operand, and the lane above becomes the more significant part. In this way the same datapath can carry one 24-bit compare, a 16-bit plus an 8-bit compare in either arrangement, or three independent 8-bit compares.

A 2-bit operation code selects the test: equality, unsigned greater-than or unsigned greater-or-equal. Each joined group yields one result, which is placed on the output bit of the lowest lane in that group. The output bits of the other lanes in a group are held at zero.

The block is purely combinational and has no state. A surrounding pipeline can register the result wherever its timing allows.

Top module: `simd_cmp`

## Requirements
- R1: Split bit k (k = 0, 1) governs the boundary between lane k and lane k+1, where lane j is operand bits [8j+7:8j]. A 1 keeps the lanes separate and a 0 joins them.
- R2: Operation code 2'b00 tests equality. A joined group reports 1 only when every lane in the group matches.
- R3: Operation code 2'b01 tests a > b and 2'b10 tests a >= b. Both are unsigned, and inside a joined group the higher lane is the more significant part.
- R4: Each group's result appears on the output bit of its lowest lane, and the output bits of the other lanes in the group are 0.
- R5: With split = 2'b11, output bit i is the result for lane i alone.
- R6: With split = 2'b00, output bit 0 is the result for the full 24-bit operands, and output bits 2:1 are 0.
- R7: Operation code 2'b11 drives all output bits to 0, whatever the operands and split bits are.
- R8: The output follows any input change with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 24 | First operand, three 8-bit lanes |
| b_i | input | 24 | Second operand, three 8-bit lanes |
| split_i | input | 2 | Boundary controls; bit k separates lane k from lane k+1 |
| op_i | input | 2 | 00 equal, 01 greater, 10 greater-or-equal, 11 none |
| res_o | output | 3 | Per-lane result, valid on the lowest lane of each group |

## Verification
The block holds no state, so a wrong internal value can only be a fault in the per-lane compare terms or in how they are chained across a joined boundary. Either fault changes res_o at once, in the same evaluation as the input change. A faulty equal-to-higher-lane carry shows up only when the upper lanes of a group tie and a lower lane decides the result. A faulty head or tail gating shows up as a 1 on a lane that is not the lowest in its group. For this reason the stimulus includes ties in the upper lanes and corner byte values on each lane, under every split pattern.

// File: rtl/simd_cmp.sv
module simd_cmp #(
  parameter int LANE_W = 8,
  parameter int LANES  = 3
) (
  input  logic [LANE_W*LANES-1:0] a_i,
  input  logic [LANE_W*LANES-1:0] b_i,
  input  logic [LANES-2:0]        split_i,
  input  logic [1:0]              op_i,
  output logic [LANES-1:0]        res_o
);
  localparam logic [1:0] OP_EQ = 2'b00;
  localparam logic [1:0] OP_GT = 2'b01;
  localparam logic [1:0] OP_GE = 2'b10;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic l_eq, l_gt, r_eq, r_gt, head, sel;
    assign l_eq = a_i[i*LANE_W +: LANE_W] == b_i[i*LANE_W +: LANE_W];
    assign l_gt = a_i[i*LANE_W +: LANE_W] >  b_i[i*LANE_W +: LANE_W];

    if (i == LANES-1) begin : g_top
      assign r_eq = l_eq;
      assign r_gt = l_gt;
    end else begin : g_chain
      assign r_eq = l_eq & (split_i[i] | g_lane[i+1].r_eq);
      assign r_gt = split_i[i] ? l_gt
                               : (g_lane[i+1].r_gt | (g_lane[i+1].r_eq & l_gt));
    end

    if (i == 0) begin : g_head0
      assign head = 1'b1;
    end else begin : g_headn
      assign head = split_i[i-1];
    end

    assign sel = (op_i == OP_EQ) ? r_eq :
                 (op_i == OP_GT) ? r_gt :
                 (op_i == OP_GE) ? (r_gt | r_eq) : 1'b0;
    assign res_o[i] = head & sel;
  end

  always_comb begin
    a_r7_reserved_quiet: assert (op_i != 2'b11 || res_o == '0);
    a_r6_whole_equal: assert (!(split_i == '0 && op_i == OP_EQ) ||
                              res_o == {{(LANES-1){1'b0}}, a_i == b_i});
    a_r2_low_lane_match: assert (!(op_i == OP_EQ && res_o[0]) ||
                                 a_i[LANE_W-1:0] == b_i[LANE_W-1:0]);
    a_r3_ge_on_tie: assert (!(op_i == OP_GE && a_i == b_i) ||
                            res_o == {split_i, 1'b1});
    for (int k = 1; k < LANES; k++) begin
      a_r4_tail_zero: assert (split_i[k-1] || !res_o[k]);
    end
  end
endmodule

// File: tb/sim_simd_cmp.sv
module sim_simd_cmp;
  localparam int CLK_PERIOD = 10;
  logic clk = 1'b0;
  logic [23:0] a = '0, b = '0;
  logic [1:0] split = '0, op = '0;
  logic [2:0] res;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_cmp u0 (.a_i(a), .b_i(b), .split_i(split), .op_i(op), .res_o(res));

  function automatic logic cmp(input logic [23:0] x, input logic [23:0] y, input logic [1:0] o);
    case (o)
      2'b00: return x == y;
      2'b01: return x > y;
      2'b10: return x >= y;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [2:0] model(input logic [23:0] x, input logic [23:0] y,
                                       input logic [1:0] g, input logic [1:0] o);
    logic [2:0] r = '0;
    case (g)
      2'b00: r[0] = cmp(x, y, o);
      2'b01: begin
        r[0] = cmp({16'd0, x[7:0]}, {16'd0, y[7:0]}, o);
        r[1] = cmp({8'd0, x[23:8]}, {8'd0, y[23:8]}, o);
      end
      2'b10: begin
        r[0] = cmp({8'd0, x[15:0]}, {8'd0, y[15:0]}, o);
        r[2] = cmp({16'd0, x[23:16]}, {16'd0, y[23:16]}, o);
      end
      default: for (int i = 0; i < 3; i++)
        r[i] = cmp({16'd0, x[8*i +: 8]}, {16'd0, y[8*i +: 8]}, o);
    endcase
    return r;
  endfunction

  task automatic chk(input string req, input logic [2:0] got, input logic [2:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s a=%h b=%h split=%b op=%b got=%b exp=%b", req, a, b, split, op, got, exp);
    end
  endtask

  task automatic apply(input logic [23:0] x, input logic [23:0] y,
                       input logic [1:0] g, input logic [1:0] o, input string req);
    @(negedge clk);
    a = x; b = y; split = g; op = o;
    #1;
    chk(req, res, model(x, y, g, o));
  endtask

  task automatic t_idle;
    #1;
    chk("R2 idle zero operands", res, 3'b001);
  endtask

  task automatic t_equal;
    apply(24'h123456, 24'h123456, 2'b00, 2'b00, "R6");
    apply(24'h123456, 24'h123457, 2'b00, 2'b00, "R6");
    apply(24'hAA0011, 24'hAB0011, 2'b01, 2'b00, "R2");
    apply(24'hAA0011, 24'hAA0012, 2'b10, 2'b00, "R2");
    apply(24'h010203, 24'h010203, 2'b11, 2'b00, "R5");
  endtask

  task automatic t_order;
    apply(24'h00FF00, 24'h010000, 2'b10, 2'b01, "R3 upper lane wins");
    apply(24'h550102, 24'h550101, 2'b01, 2'b01, "R3 tie then lower");
    apply(24'h550101, 24'h550102, 2'b00, 2'b10, "R3");
    apply(24'h550101, 24'h550101, 2'b00, 2'b10, "R3 ge tie");
    apply(24'h800000, 24'h7FFFFF, 2'b00, 2'b01, "R6 unsigned");
    apply(24'hFF00FF, 24'h00FF00, 2'b11, 2'b01, "R5");
    apply(24'h000100, 24'h000001, 2'b10, 2'b01, "R1 join 0-1");
  endtask

  task automatic t_reserved;
    apply(24'h0, 24'h0, 2'b11, 2'b11, "R7");
    apply(24'hFFFFFF, 24'h0, 2'b00, 2'b11, "R7");
    chk("R7 explicit", res, 3'b000);
  endtask

  task automatic t_comb;
    @(negedge clk);
    a = 24'h00_00_05; b = 24'h00_00_05; split = 2'b11; op = 2'b00;
    #1; chk("R8 first", res, 3'b111);
    b = 24'h00_00_06;
    #1; chk("R8 follows", res, 3'b110);
  endtask

  task automatic t_corners;
    logic [7:0] cv [6] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFE, 8'hFF};
    for (int ln = 0; ln < 3; ln++)
      for (int p = 0; p < 6; p++)
        for (int q = 0; q < 6; q++)
          for (int g = 0; g < 4; g++)
            for (int o = 0; o < 4; o++) begin
              logic [23:0] x, y;
              x = 24'h5A5A5A; y = 24'h5A5A5A;
              x[8*ln +: 8] = cv[p]; y[8*ln +: 8] = cv[q];
              apply(x, y, g[1:0], o[1:0], "R4 corners");
            end
  endtask

  task automatic t_random;
    for (int n = 0; n < 400; n++) begin
      logic [23:0] x, y;
      x = $urandom; y = $urandom;
      if (n % 3 == 0) y[23:8] = x[23:8];
      apply(x, y, n[1:0], n[3:2], "R1 random");
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_idle();
    t_equal();
    t_order();
    t_reserved();
    t_comb();
    t_corners();
    t_random();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule